// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is an on-chip single-port memory whose control interface is registered on every rising clock edge. Each enabled edge either loads a new access (address, read or write, byte-lane enables, chip enable) or advances a four-beat burst from the last loaded base address. Write data follows its address by two enabled edges. Read data appears two enabled edges after its address. Because both directions have the same delay, reads and writes can alternate on every cycle and the shared data bus never needs an idle cycle.

A read that enters the pipeline while a write to the same word is still committing returns the new bytes. The bytes that the write does not touch come from the stored word. The burst counter works on the two lowest address bits. It steps either linearly or by XOR with the base, and it returns to the base after four beats. A clock-enable input stalls the whole pipeline, including the burst state, for any cycle.

Top module: `zbt_sram`

## Requirements
- R1: After reset, `rvalid` is low. Burst-advance cycles issued before any load produce no reads and no writes.
- R2: When `load_n` is low at an enabled edge, the address and cycle type are captured. If `ce_n` is high, the cycle is a deselect: `rvalid` is low after the second enabled edge that follows, and no word is written.
- R3: For a loaded write, `byte_we_n` is taken at the address edge and `wdata` is taken at the second enabled edge after it. Lane i is `wdata[9*i +: 9]`. A lane is written only when `byte_we_n[i]` is 0, and the other lanes keep their contents.
- R4: For a read whose address is taken at edge k, `rvalid` is high and `rdata` holds the word after edge k+2, counting enabled edges only.
- R5: Reads and writes may alternate on consecutive enabled edges with no idle cycle, and every read still returns the value left by all earlier-issued writes.
- R6: A read issued on the edge after a write to the same address returns the new data in the enabled lanes and the old stored data in the other lanes.
- R7: When `load_n` is high, the access keeps the type of the burst and uses the base address with its two lowest bits replaced by the burst offset. The offset counter goes 0, 1, 2, 3 and then wraps to 0, so the fifth beat repeats the base.
- R8: When `order_sel` is 0, the burst offset is (base + count) mod 4. When `order_sel` is 1, it is base XOR count.
- R9: While `cke_n` is high, the pipeline, the burst counter and the memory do not change, and `rvalid` and `rdata` hold their values.
- R10: Burst advances that follow a deselect load stay deselected: they produce no `rvalid` and no writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke_n | input | 1 | Clock enable, active low. When high, the cycle is stalled |
| load_n | input | 1 | Low loads a new access. High advances the burst |
| ce_n | input | 1 | Chip enable at load, active low. High selects a deselect cycle |
| wr_en | input | 1 | At load: 1 selects a write, 0 selects a read |
| addr | input | ADDR_W | Word address taken at load |
| byte_we_n | input | LANES | Per-lane write enables, active low |
| order_sel | input | 1 | Burst order: 0 is linear, 1 is interleaved |
| wdata | input | LANES*LANE_W | Write data, taken two enabled edges after its address |
| rdata | output | LANES*LANE_W | Read data |
| rvalid | output | 1 | High when rdata carries the result of a read |

## Verification
The hardest case to reach is a read that lands on the same word in the cycle its earlier write commits. The array read and the write happen on one edge, so the stored value is stale and only the forwarding path gives the right bytes. The bench reaches this case with a dedicated sweep. Each write uses a different byte-enable pattern and is followed at once by a read of the same word. A long random phase confined to eight addresses then mixes bursts, deselects and stalls, and checks every output against a behavioural model kept in the bench.

// File: rtl/zbt_pkg.sv
// Shared types and helpers for the pipelined zero-turnaround SRAM.
// Assumes the two lowest address bits form the burst offset.
package zbt_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Burst offset: linear sum or XOR of base and beat count.
    function automatic logic [1:0] burst_offset(input logic [1:0] base,
                                                input logic [1:0] count,
                                                input logic       interleave);
        return interleave ? (base ^ count) : (base + count);
    endfunction

endpackage

// File: rtl/zbt_burst_ctl.sv
// Load/advance front end. On a load it decodes the cycle type and passes
// the external address through. On an advance it keeps the stored type and
// forms the next beat address from the stored base.
// Assumes ADDR_W >= 3. The state is frozen while cke_n is high.
module zbt_burst_ctl
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_n,
    input  logic              load_n,
    input  logic              ce_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              order_sel,
    output op_e               cur_op,
    output logic [ADDR_W-1:0] cur_addr
);
    logic [ADDR_W-1:0] base_q;
    logic [1:0]        count_q;
    logic [1:0]        count_nx;
    op_e               burst_op_q;

    // Decode the access presented on this edge.
    always_comb begin
        count_nx = count_q + 2'd1;
        if (!load_n) begin
            cur_addr = addr;
            if (ce_n)
                cur_op = OP_IDLE;
            else
                cur_op = wr_en ? OP_WRITE : OP_READ;
        end else begin
            cur_op   = burst_op_q;
            cur_addr = {base_q[ADDR_W-1:2], burst_offset(base_q[1:0], count_nx, order_sel)};
        end
    end

    // Hold the burst base, beat count and cycle type.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q     <= '0;
            count_q    <= '0;
            burst_op_q <= OP_IDLE;
        end else if (!cke_n) begin
            if (!load_n) begin
                base_q     <= addr;
                count_q    <= '0;
                burst_op_q <= cur_op;
            end else begin
                count_q    <= count_nx;
            end
        end
    end

endmodule

// File: rtl/zbt_array.sv
// Word storage with per-lane write enables and a registered read port.
// A read and a write to the same word on one edge return the old word.
// The storage itself has no reset; only the read register is cleared.
module zbt_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANES-1:0]  wr_lanes,
    input  logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Commit the enabled lanes of a write.
    always_ff @(posedge clk) begin
        if (en && wr_en) begin
            for (int i = 0; i < LANES; i++) begin
                if (wr_lanes[i])
                    mem[wr_addr][i*LANE_W +: LANE_W] <= wr_data[i*LANE_W +: LANE_W];
            end
        end
    end

    // Register the addressed word for a read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (en && rd_en)
            rd_data <= mem[rd_addr];
    end

endmodule

// File: rtl/zbt_bypass.sv
// Write-to-read forwarding. When a read samples the array on the same edge
// that a write to the same word commits, the write data and its lanes are
// recorded. On the next cycle those lanes replace the stale array output.
module zbt_bypass #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANES-1:0]  wr_lanes,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] merged
);
    logic [LANES-1:0]  hit_q;
    logic [DATA_W-1:0] fwd_q;

    // Record the lanes of a colliding write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= '0;
            fwd_q <= '0;
        end else if (en) begin
            hit_q <= (rd_en && wr_en && (rd_addr == wr_addr)) ? wr_lanes : '0;
            fwd_q <= wr_data;
        end
    end

    // Per-lane choice between forwarded and stored bytes.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*LANE_W +: LANE_W] = hit_q[g] ? fwd_q[g*LANE_W +: LANE_W]
                                                     : arr_data[g*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/zbt_sram.sv
// Pipelined zero-turnaround SRAM top. Stage 1 holds the access loaded or
// advanced on the previous edge and reads the array. Stage 2 commits a write
// with the wdata present now, or presents read data through the bypass.
// Both directions have a latency of two enabled edges. cke_n high stalls all.
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_n,
    input  logic              load_n,
    input  logic              ce_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  byte_we_n,
    input  logic              order_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    op_e               cur_op;
    logic [ADDR_W-1:0] cur_addr;
    op_e               s1_op, s2_op;
    logic [ADDR_W-1:0] s1_addr, s2_addr;
    logic [LANES-1:0]  s1_be_n, s2_be_n;
    logic [DATA_W-1:0] arr_q;
    logic [DATA_W-1:0] merged;
    logic              en;
    logic              s1_rd, s2_wr;

    assign en    = !cke_n;
    assign s1_rd = (s1_op == OP_READ);
    assign s2_wr = (s2_op == OP_WRITE);

    zbt_burst_ctl #(.ADDR_W(ADDR_W)) u_burst (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .load_n(load_n),
        .ce_n(ce_n), .wr_en(wr_en), .addr(addr), .order_sel(order_sel),
        .cur_op(cur_op), .cur_addr(cur_addr)
    );

    zbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk(clk), .rst_n(rst_n), .en(en),
        .rd_en(s1_rd), .rd_addr(s1_addr), .rd_data(arr_q),
        .wr_en(s2_wr), .wr_addr(s2_addr), .wr_lanes(~s2_be_n), .wr_data(wdata)
    );

    zbt_bypass #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_bypass (
        .clk(clk), .rst_n(rst_n), .en(en),
        .rd_en(s1_rd), .rd_addr(s1_addr),
        .wr_en(s2_wr), .wr_addr(s2_addr), .wr_lanes(~s2_be_n), .wr_data(wdata),
        .arr_data(arr_q), .merged(merged)
    );

    // Advance the two-stage access pipeline and the read output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_op   <= OP_IDLE;
            s2_op   <= OP_IDLE;
            s1_addr <= '0;
            s2_addr <= '0;
            s1_be_n <= '1;
            s2_be_n <= '1;
            rvalid  <= 1'b0;
            rdata   <= '0;
        end else if (en) begin
            s1_op   <= cur_op;
            s1_addr <= cur_addr;
            s1_be_n <= byte_we_n;
            s2_op   <= s1_op;
            s2_addr <= s1_addr;
            s2_be_n <= s1_be_n;
            rvalid  <= (s2_op == OP_READ);
            if (s2_op == OP_READ)
                rdata <= merged;
        end
    end

endmodule

// File: rtl/zbt_sram_chk.sv
// Port-level checker for zbt_sram, attached with bind. A small counter of
// edges since reset keeps every $past inside the post-reset window.
module zbt_sram_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke_n,
    input logic              load_n,
    input logic              ce_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] rdata,
    input logic              rvalid
);
    logic [1:0] age;

    // Count edges since reset release, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)
            age <= '0;
        else if (age != 2'd3)
            age <= age + 2'd1;
    end

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd3) |-> !rvalid); // R1

    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && cke_n) |=> ($stable(rvalid) && $stable(rdata))); // R9

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && !cke_n && !$past(cke_n) && !$past(cke_n, 2) &&
         !$past(load_n, 2) && !$past(ce_n, 2) && !$past(wr_en, 2)) |=> rvalid); // R4

    AST_WRITE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && !cke_n && !$past(cke_n) && !$past(cke_n, 2) &&
         !$past(load_n, 2) && !$past(ce_n, 2) && $past(wr_en, 2)) |=> !rvalid); // R3

    AST_DESELECT_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && !cke_n && !$past(cke_n) && !$past(cke_n, 2) &&
         !$past(load_n, 2) && $past(ce_n, 2)) |=> !rvalid); // R2

endmodule

bind zbt_sram zbt_sram_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .load_n(load_n), .ce_n(ce_n),
    .wr_en(wr_en), .rdata(rdata), .rvalid(rvalid)
);

// File: tb/zbt_sram_tb_top.sv
`timescale 1ns/1ps
module zbt_sram_tb_top;
    localparam int ADDR_W = 6;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int DATA_W = LANES * LANE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cke_n = 1'b0;
    logic              load_n = 1'b1;
    logic              ce_n = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [LANES-1:0]  byte_we_n = '1;
    logic              order_sel = 1'b0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              rvalid;

    always #10 clk = ~clk;

    zbt_sram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .load_n(load_n), .ce_n(ce_n),
        .wr_en(wr_en), .addr(addr), .byte_we_n(byte_we_n), .order_sel(order_sel),
        .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
    );

    // Behavioural model state (0 idle, 1 read, 2 write).
    logic [DATA_W-1:0] m_mem [DEPTH];
    int                p1_op, p2_op, m_bop;
    logic [ADDR_W-1:0] p1_a, p2_a, m_base;
    logic [LANES-1:0]  p1_be, p2_be;
    logic [1:0]        m_cnt;
    logic              exp_valid;
    logic [DATA_W-1:0] exp_data;
    int                checks = 0, errors = 0, cyc = 0;
    string             cur_req = "R1";
    bit                done = 0;

    task automatic model_reset();
        p1_op = 0; p2_op = 0; m_bop = 0; m_base = '0; m_cnt = '0;
        p1_a = '0; p2_a = '0; p1_be = '1; p2_be = '1;
        exp_valid = 1'b0;
    endtask

    // Model one rising edge using the inputs presently driven.
    task automatic model_edge();
        int                c_op;
        logic [ADDR_W-1:0] c_a;
        logic [1:0]        off;
        if (!rst_n) begin model_reset(); return; end
        if (cke_n) return;
        if (!load_n) begin
            c_op = ce_n ? 0 : (wr_en ? 2 : 1);
            c_a = addr;
            m_base = addr; m_cnt = 2'd0; m_bop = c_op;
        end else begin
            m_cnt = m_cnt + 2'd1;
            off = order_sel ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
            c_op = m_bop;
            c_a = {m_base[ADDR_W-1:2], off};
        end
        exp_valid = (p2_op == 1);
        if (p2_op == 1) exp_data = m_mem[p2_a];
        if (p2_op == 2)
            for (int i = 0; i < LANES; i++)
                if (!p2_be[i]) m_mem[p2_a][i*LANE_W +: LANE_W] = wdata[i*LANE_W +: LANE_W];
        p2_op = p1_op; p2_a = p1_a; p2_be = p1_be;
        p1_op = c_op;  p1_a = c_a;  p1_be = byte_we_n;
    endtask

    task automatic check_outputs();
        checks++;
        if (rvalid !== exp_valid) begin
            errors++;
            $display("FAIL %s rvalid actual %b expected %b (cycle %0d)", cur_req, rvalid, exp_valid, cyc);
        end
        if (exp_valid) begin
            checks++;
            if (rdata !== exp_data) begin
                errors++;
                $display("FAIL %s rdata actual %h expected %h (cycle %0d)", cur_req, rdata, exp_data, cyc);
            end
        end
    endtask

    // One cycle: drive inputs, take the edge, check after the edge.
    task automatic step(input logic ld_n, input logic cen, input logic wr,
                        input logic [ADDR_W-1:0] a, input logic [LANES-1:0] be,
                        input logic stall);
        logic [63:0] h;
        h = {32'd0, 32'(cyc)} * 64'h9E3779B97F4A7C15;
        load_n = ld_n; ce_n = cen; wr_en = wr; addr = a; byte_we_n = be;
        cke_n = stall; wdata = h[63:28];
        @(posedge clk);
        model_edge();
        cyc++;
        @(negedge clk);
        if (rst_n) check_outputs();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b1, 1'b0, '0, '1, 1'b0);
    endtask

    task automatic finish_run();
        if (done) return;
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL %s watchdog actual running expected finished", cur_req);
        finish_run();
    end

    initial begin
        model_reset();
        @(negedge clk);
        step(1'b1, 1'b1, 1'b0, '0, '1, 1'b0);
        step(1'b1, 1'b1, 1'b0, '0, '1, 1'b0);
        rst_n = 1'b1;
        // R1: reset state, then advances with no load
        cur_req = "R1";
        checks++;
        if (rvalid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset rvalid actual %b expected 0", rvalid);
        end
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b1, '0, '0, 1'b0);

        // R3: fill every word with full-lane writes
        cur_req = "R3";
        for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b0, 1'b1, ADDR_W'(i), '0, 1'b0);
        idle(2);

        // R4: read every word back
        cur_req = "R4";
        for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b0, 1'b0, ADDR_W'(i), '1, 1'b0);
        idle(2);

        // R5: alternate write and read on consecutive edges
        cur_req = "R5";
        for (int i = 0; i < DEPTH; i++) begin
            step(1'b0, 1'b0, 1'b1, ADDR_W'(i), '0, 1'b0);
            step(1'b0, 1'b0, 1'b0, ADDR_W'(i ^ 5), '1, 1'b0);
        end
        idle(2);

        // R3: each byte-enable pattern, read back later
        cur_req = "R3";
        for (int p = 0; p < 16; p++) step(1'b0, 1'b0, 1'b1, ADDR_W'(32 + p), LANES'(p), 1'b0);
        idle(2);
        for (int p = 0; p < 16; p++) step(1'b0, 1'b0, 1'b0, ADDR_W'(32 + p), '1, 1'b0);
        idle(2);

        // R6: read immediately after a partial write to the same word
        cur_req = "R6";
        for (int p = 0; p < 16; p++) begin
            step(1'b0, 1'b0, 1'b1, ADDR_W'(p & 7), LANES'(p), 1'b0);
            step(1'b0, 1'b0, 1'b0, ADDR_W'(p & 7), '1, 1'b0);
        end
        idle(2);

        // R7 / R8: six-beat bursts from every offset in both orders
        for (int o = 0; o < 2; o++) begin
            order_sel = o[0];
            cur_req = (o == 0) ? "R7" : "R8";
            for (int b = 0; b < 4; b++) begin
                step(1'b0, 1'b0, 1'b1, ADDR_W'(16 + b), '0, 1'b0);
                for (int k = 0; k < 5; k++) step(1'b1, 1'b0, 1'b0, '0, LANES'(k), 1'b0);
                idle(2);
                step(1'b0, 1'b0, 1'b0, ADDR_W'(16 + b), '1, 1'b0);
                for (int k = 0; k < 5; k++) step(1'b1, 1'b1, 1'b1, '0, '0, 1'b0);
                idle(2);
                for (int k = 0; k < 4; k++) step(1'b0, 1'b0, 1'b0, ADDR_W'(16 + k), '1, 1'b0);
                idle(2);
            end
        end
        order_sel = 1'b0;

        // R2 / R10: deselect load followed by write-looking advances
        cur_req = "R10";
        step(1'b0, 1'b1, 1'b1, ADDR_W'(20), '0, 1'b0);
        for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 1'b1, '0, '0, 1'b0);
        idle(2);
        cur_req = "R2";
        for (int k = 0; k < 4; k++) step(1'b0, 1'b0, 1'b0, ADDR_W'(20 + k), '1, 1'b0);
        idle(2);

        // R9: stalls between writes and reads
        cur_req = "R9";
        for (int i = 0; i < 24; i++)
            step(1'b0, 1'b0, i[1], ADDR_W'(i & 3), LANES'(i), (i % 3) == 1);
        idle(3);

        // R5: mixed random traffic on eight words
        cur_req = "R5";
        for (int i = 0; i < 3000; i++) begin
            order_sel = $urandom_range(0, 7) == 0 ? ~order_sel : order_sel;
            step($urandom_range(0, 3) == 0, $urandom_range(0, 9) == 0, 1'($urandom),
                 ADDR_W'($urandom_range(0, 7)), LANES'($urandom),
                 $urandom_range(0, 9) == 0);
        end
        idle(3);
        finish_run();
    end
endmodule